// File: doc/BRIEF.md
# Dual-FIFO Debug Console Peripheral

This block is a memory-mapped character console. It sits between a processor bus and a host-side byte link. Bytes from the host go into a receive FIFO, and the processor drains that FIFO by reading the data register. Bytes that the processor writes to the data register go into a transmit FIFO, and the host link drains it.

A control register does three jobs. It holds the two interrupt enables. It reports pending conditions, the overflow and host-activity flags, and the free transmit space. It also clears the sticky flags by write-one.

On the host side the block uses byte-wide valid/ready streams. A one-cycle poll strobe marks host activity. A level signal tells the block that no more input is coming.

The bus access is single-cycle. An access is taken when `bus_sel` is high. `bus_addr` 0 selects the data register and `bus_addr` 1 selects the control register. A read of the data register pops the receive FIFO at the same clock edge that completes the access.

Top module: `dbgc_console`

## Requirements
- R1: Each FIFO holds 2^LOG_DEPTH bytes (LOG_DEPTH from 3 to 15, default 6, so 64 bytes). `host_rx_ready` is low exactly when the receive FIFO holds 2^LOG_DEPTH bytes. While `host_rx_ready` is low, an offered byte is not taken.
- R2: The receive pending condition (control bit 8) is 1 whenever the receive free space (depth minus occupancy) is at most RX_THRESH (default 8).
- R3: The receive pending condition is also 1 while `host_eoi` is high and the receive FIFO holds at least one byte.
- R4: The transmit pending condition (control bit 9) is 1 whenever transmit occupancy is at most TX_THRESH (default 8). It returns to 0 only once occupancy rises above TX_THRESH.
- R5: A data-register read returns the head byte in bits 7:0, a valid flag in bit 15, and in bits 31:16 the receive count left after the pop. The same access pops the byte. On an empty receive FIFO the read returns all zeros and pops nothing.
- R6: A data-register write pushes bits 7:0 into the transmit FIFO. `host_tx_valid`/`host_tx_data` present the bytes in write order. A byte leaves the FIFO when valid and `host_tx_ready` are both high.
- R7: A data-register write while the transmit FIFO is full is dropped and sets the sticky overflow bit (control bit 11). Writing 1 to bit 11 clears it.
- R8: A `host_poll` pulse sets the host-activity bit (control bit 10). The bit stays set until a control write with bit 10 at 1. If a poll and such a clear happen in the same cycle, the bit stays set.
- R9: Control bits 0 and 1 are the receive and transmit interrupt enables (read/write, reset 0). `irq` is (rx pending AND bit 0) OR (tx pending AND bit 1).
- R10: Control bits 31:16 read the free transmit space (depth minus occupancy). Bits 8 and 9 read the pending conditions, and all other unassigned bits read 0.
- R11: `bus_rdata` is 0 in any cycle without a read access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = data register, 1 = control register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq | output | 1 | Interrupt request |
| host_rx_valid | input | 1 | Host offers a receive byte |
| host_rx_data | input | 8 | Receive byte from host |
| host_rx_ready | output | 1 | Receive FIFO can accept |
| host_tx_valid | output | 1 | Transmit byte available |
| host_tx_data | output | 8 | Transmit head byte |
| host_tx_ready | input | 1 | Host takes the transmit byte |
| host_poll | input | 1 | Host activity strobe |
| host_eoi | input | 1 | Host has no further input |

## Verification
The hardest states to reach are the receive FIFO exactly at and beyond full, and a data read and a host push landing in the same cycle at that boundary. The stimulus reaches full by streaming more host bytes than the depth with the processor idle. It reads the control register after every byte to catch the cycle in which free space first equals the threshold. It then interleaves pops with held-valid pushes while the FIFO is full.

The early receive interrupt is reached by leaving only a few bytes queued and raising end-of-input. For overflow, the transmit FIFO is filled with the host stalled, and writes continue past full.

// File: rtl/dbgc_pkg.sv
package dbgc_pkg;
   localparam logic REG_DATA = 1'b0;
   localparam logic REG_CTRL = 1'b1;

   localparam int CB_RX_IE   = 0;
   localparam int CB_TX_IE   = 1;
   localparam int CB_RX_PEND = 8;
   localparam int CB_TX_PEND = 9;
   localparam int CB_ACT     = 10;
   localparam int CB_OVF     = 11;
   localparam int DB_VALID   = 15;
endpackage

// File: rtl/dbgc_fifo.sv
module dbgc_fifo #(
   parameter int LOG_DEPTH     = 6,
   parameter bit CLEAR_STORAGE = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               push,
   input  logic [7:0]         din,
   input  logic               pop,
   output logic [7:0]         dout,
   output logic [LOG_DEPTH:0] count,
   output logic               full,
   output logic               empty
);
   localparam int DEPTH = 1 << LOG_DEPTH;
   localparam int CW    = LOG_DEPTH + 1;

   logic [LOG_DEPTH-1:0] wp, rp;
   logic [CW-1:0]        cnt;
   logic [7:0]           mem [DEPTH];
   logic                 do_push, do_pop;

   assign full    = (cnt == CW'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rp];
   assign count   = cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   generate
      if (CLEAR_STORAGE) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (do_push) begin
               mem[wp] <= din;
            end
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (do_push) mem[wp] <= din;
         end
      end
   endgenerate
endmodule

// File: rtl/dbgc_irq.sv
module dbgc_irq #(
   parameter int LOG_DEPTH = 6,
   parameter int RX_THRESH = 8,
   parameter int TX_THRESH = 8,
   parameter bit EOI_EARLY = 1'b1
) (
   input  logic [LOG_DEPTH:0] rx_cnt,
   input  logic [LOG_DEPTH:0] tx_cnt,
   input  logic               host_eoi,
   input  logic               rx_ie,
   input  logic               tx_ie,
   output logic               rx_pend,
   output logic               tx_pend,
   output logic               irq
);
   localparam int CW = LOG_DEPTH + 1;
   localparam logic [CW-1:0] DEPTH_C = CW'(1 << LOG_DEPTH);
   localparam logic [CW-1:0] RXT_C   = CW'(RX_THRESH);
   localparam logic [CW-1:0] TXT_C   = CW'(TX_THRESH);

   logic [CW-1:0] rx_free;
   logic          rx_level;
   logic          eoi_term;

   assign rx_free  = DEPTH_C - rx_cnt;
   assign rx_level = (rx_free <= RXT_C);

   generate
      if (EOI_EARLY) begin : g_eoi
         assign eoi_term = host_eoi && (rx_cnt != '0);
      end else begin : g_no_eoi
         logic unused_eoi;
         assign unused_eoi = host_eoi;
         assign eoi_term   = 1'b0;
      end
   endgenerate

   assign rx_pend = rx_level || eoi_term;
   assign tx_pend = (tx_cnt <= TXT_C);
   assign irq     = (rx_pend && rx_ie) || (tx_pend && tx_ie);
endmodule

// File: rtl/dbgc_ctrl.sv
module dbgc_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic ctrl_wr,
   input  logic wr_rx_ie,
   input  logic wr_tx_ie,
   input  logic wr_clr_act,
   input  logic wr_clr_ovf,
   input  logic poll,
   input  logic ovf_evt,
   output logic rx_ie,
   output logic tx_ie,
   output logic host_act,
   output logic tx_ovf
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_ie    <= 1'b0;
         tx_ie    <= 1'b0;
         host_act <= 1'b0;
         tx_ovf   <= 1'b0;
      end else begin
         if (ctrl_wr) begin
            rx_ie <= wr_rx_ie;
            tx_ie <= wr_tx_ie;
         end
         if (poll)                         host_act <= 1'b1;
         else if (ctrl_wr && wr_clr_act)   host_act <= 1'b0;
         if (ovf_evt)                      tx_ovf <= 1'b1;
         else if (ctrl_wr && wr_clr_ovf)   tx_ovf <= 1'b0;
      end
   end
endmodule

// File: rtl/dbgc_console.sv
module dbgc_console #(
   parameter int LOG_DEPTH     = 6,
   parameter int RX_THRESH     = 8,
   parameter int TX_THRESH     = 8,
   parameter bit EOI_EARLY     = 1'b1,
   parameter bit CLEAR_STORAGE = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_sel,
   input  logic        bus_wr,
   input  logic        bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        irq,
   input  logic        host_rx_valid,
   input  logic [7:0]  host_rx_data,
   output logic        host_rx_ready,
   output logic        host_tx_valid,
   output logic [7:0]  host_tx_data,
   input  logic        host_tx_ready,
   input  logic        host_poll,
   input  logic        host_eoi
);
   import dbgc_pkg::*;

   localparam int DEPTH = 1 << LOG_DEPTH;
   localparam int CW    = LOG_DEPTH + 1;
   localparam logic [15:0] DEPTH16 = 16'(DEPTH);

   generate
      if (LOG_DEPTH < 3 || LOG_DEPTH > 15) begin : g_bad_depth
         $error("dbgc_console: LOG_DEPTH must lie in 3..15");
      end
      if (RX_THRESH < 0 || RX_THRESH > DEPTH) begin : g_bad_rxt
         $error("dbgc_console: RX_THRESH out of range");
      end
      if (TX_THRESH < 0 || TX_THRESH > DEPTH) begin : g_bad_txt
         $error("dbgc_console: TX_THRESH out of range");
      end
   endgenerate

   logic          rd_data_acc, wr_data_acc, wr_ctrl_acc;
   logic [7:0]    rx_dout;
   logic [CW-1:0] rx_cnt, tx_cnt;
   logic          rx_full, rx_empty, tx_full, tx_empty;
   logic          rx_pend, tx_pend;
   logic          rx_ie, tx_ie, host_act, tx_ovf;
   logic [15:0]   rx_left, tx_free;
   logic          unused_wdata;

   assign rd_data_acc = bus_sel && !bus_wr && (bus_addr == REG_DATA);
   assign wr_data_acc = bus_sel &&  bus_wr && (bus_addr == REG_DATA);
   assign wr_ctrl_acc = bus_sel &&  bus_wr && (bus_addr == REG_CTRL);
   assign unused_wdata = ^{bus_wdata[31:12], bus_wdata[9:8]};

   dbgc_fifo #(.LOG_DEPTH(LOG_DEPTH), .CLEAR_STORAGE(CLEAR_STORAGE)) u_rx_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (host_rx_valid),
      .din   (host_rx_data),
      .pop   (rd_data_acc),
      .dout  (rx_dout),
      .count (rx_cnt),
      .full  (rx_full),
      .empty (rx_empty)
   );

   dbgc_fifo #(.LOG_DEPTH(LOG_DEPTH), .CLEAR_STORAGE(CLEAR_STORAGE)) u_tx_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (wr_data_acc),
      .din   (bus_wdata[7:0]),
      .pop   (host_tx_ready),
      .dout  (host_tx_data),
      .count (tx_cnt),
      .full  (tx_full),
      .empty (tx_empty)
   );

   dbgc_irq #(
      .LOG_DEPTH (LOG_DEPTH),
      .RX_THRESH (RX_THRESH),
      .TX_THRESH (TX_THRESH),
      .EOI_EARLY (EOI_EARLY)
   ) u_irq (
      .rx_cnt   (rx_cnt),
      .tx_cnt   (tx_cnt),
      .host_eoi (host_eoi),
      .rx_ie    (rx_ie),
      .tx_ie    (tx_ie),
      .rx_pend  (rx_pend),
      .tx_pend  (tx_pend),
      .irq      (irq)
   );

   dbgc_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctrl_wr    (wr_ctrl_acc),
      .wr_rx_ie   (bus_wdata[CB_RX_IE]),
      .wr_tx_ie   (bus_wdata[CB_TX_IE]),
      .wr_clr_act (bus_wdata[CB_ACT]),
      .wr_clr_ovf (bus_wdata[CB_OVF]),
      .poll       (host_poll),
      .ovf_evt    (wr_data_acc && tx_full),
      .rx_ie      (rx_ie),
      .tx_ie      (tx_ie),
      .host_act   (host_act),
      .tx_ovf     (tx_ovf)
   );

   assign host_rx_ready = !rx_full;
   assign host_tx_valid = !tx_empty;
   assign rx_left       = 16'(rx_cnt) - 16'd1;
   assign tx_free       = DEPTH16 - 16'(tx_cnt);

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr) begin
         if (bus_addr == REG_DATA) begin
            if (!rx_empty) begin
               bus_rdata[7:0]      = rx_dout;
               bus_rdata[DB_VALID] = 1'b1;
               bus_rdata[31:16]    = rx_left;
            end
         end else begin
            bus_rdata[CB_RX_IE]   = rx_ie;
            bus_rdata[CB_TX_IE]   = tx_ie;
            bus_rdata[CB_RX_PEND] = rx_pend;
            bus_rdata[CB_TX_PEND] = tx_pend;
            bus_rdata[CB_ACT]     = host_act;
            bus_rdata[CB_OVF]     = tx_ovf;
            bus_rdata[31:16]      = tx_free;
         end
      end
   end
endmodule

// File: rtl/dbgc_chk.sv
module dbgc_chk #(
   parameter int LOG_DEPTH = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic               rd_data_acc,
   input logic               wr_data_acc,
   input logic               wr_ctrl_acc,
   input logic [31:0]        bus_wdata,
   input logic [31:0]        bus_rdata,
   input logic [LOG_DEPTH:0] rx_cnt,
   input logic [LOG_DEPTH:0] tx_cnt,
   input logic               host_rx_valid,
   input logic               host_rx_ready,
   input logic               host_tx_valid,
   input logic               host_tx_ready,
   input logic               host_poll,
   input logic               host_act,
   input logic               tx_ovf,
   input logic               rx_ie,
   input logic               tx_ie,
   input logic               irq
);
   localparam int CW = LOG_DEPTH + 1;
   localparam logic [CW-1:0] DEPTH_C = CW'(1 << LOG_DEPTH);

   // R1
   rx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_cnt <= DEPTH_C);

   // R8
   poll_sets_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_poll |=> host_act);

   // R8
   act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_act && !(wr_ctrl_acc && bus_wdata[10])) |=> host_act);

   // R7
   ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data_acc && tx_cnt == DEPTH_C) |=> tx_ovf);

   // R7
   drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data_acc && tx_cnt == DEPTH_C && !(host_tx_valid && host_tx_ready))
      |=> (tx_cnt == DEPTH_C));

   // R5
   empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data_acc && rx_cnt == '0 && !(host_rx_valid && host_rx_ready))
      |=> (rx_cnt == '0));

   // R5
   valid_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data_acc |-> (bus_rdata[15] == (rx_cnt != '0)));

   // R9
   irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_ie && !tx_ie) |-> !irq);
endmodule

bind dbgc_console dbgc_chk #(.LOG_DEPTH(LOG_DEPTH)) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .rd_data_acc   (rd_data_acc),
   .wr_data_acc   (wr_data_acc),
   .wr_ctrl_acc   (wr_ctrl_acc),
   .bus_wdata     (bus_wdata),
   .bus_rdata     (bus_rdata),
   .rx_cnt        (rx_cnt),
   .tx_cnt        (tx_cnt),
   .host_rx_valid (host_rx_valid),
   .host_rx_ready (host_rx_ready),
   .host_tx_valid (host_tx_valid),
   .host_tx_ready (host_tx_ready),
   .host_poll     (host_poll),
   .host_act      (host_act),
   .tx_ovf        (tx_ovf),
   .rx_ie         (rx_ie),
   .tx_ie         (tx_ie),
   .irq           (irq)
);

// File: tb/test_dbgc_console.sv
`timescale 1ns/1ps
module test_dbgc_console;
   localparam int DEPTH = 64;
   localparam int RXT   = 8;
   localparam int TXT   = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;
   logic        host_rx_valid = 1'b0;
   logic [7:0]  host_rx_data = '0;
   logic        host_rx_ready, host_tx_valid;
   logic [7:0]  host_tx_data;
   logic        host_tx_ready = 1'b0, host_poll = 1'b0, host_eoi = 1'b0;

   int n_tests = 0;
   int n_fail  = 0;

   logic [7:0] rxq[$];
   logic [7:0] txq[$];
   logic m_rx_ie = 0, m_tx_ie = 0, m_act = 0, m_ovf = 0;

   always #2.5 clk = ~clk;

   dbgc_console i_dbgc_console (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .host_rx_valid(host_rx_valid), .host_rx_data(host_rx_data),
      .host_rx_ready(host_rx_ready), .host_tx_valid(host_tx_valid),
      .host_tx_data(host_tx_data), .host_tx_ready(host_tx_ready),
      .host_poll(host_poll), .host_eoi(host_eoi)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic m_rxp();
      return ((DEPTH - rxq.size()) <= RXT) || (host_eoi && rxq.size() > 0);
   endfunction
   function automatic logic m_txp();
      return txq.size() <= TXT;
   endfunction

   task automatic compare();
      logic [31:0] exp_d;
      chk("R1 rx_ready", 32'(host_rx_ready), 32'(rxq.size() < DEPTH));
      chk("R6 tx_valid", 32'(host_tx_valid), 32'(txq.size() > 0));
      if (txq.size() > 0) chk("R6 tx_data", 32'(host_tx_data), 32'(txq[0]));
      chk("R9 irq", 32'(irq), 32'((m_rxp() && m_rx_ie) || (m_txp() && m_tx_ie)));
      if (bus_sel && !bus_wr && bus_addr == 1'b0) begin
         exp_d = '0;
         if (rxq.size() > 0) exp_d = {16'(rxq.size() - 1), 8'h80, rxq[0]};
         chk("R5 data read", bus_rdata, exp_d);
      end else if (bus_sel && !bus_wr) begin
         chk("R2 R3 rx pending", 32'(bus_rdata[8]), 32'(m_rxp()));
         chk("R4 tx pending", 32'(bus_rdata[9]), 32'(m_txp()));
         chk("R8 activity", 32'(bus_rdata[10]), 32'(m_act));
         chk("R7 overflow", 32'(bus_rdata[11]), 32'(m_ovf));
         chk("R9 enables", 32'(bus_rdata[1:0]), {30'd0, m_tx_ie, m_rx_ie});
         chk("R10 tx free", 32'(bus_rdata[31:16]), 32'(DEPTH - txq.size()));
         chk("R10 zero bits", {20'd0, bus_rdata[15:12], bus_rdata[7:2]}, 32'd0);
      end else begin
         chk("R11 idle rdata", bus_rdata, 32'd0);
      end
   endtask

   task automatic update();
      bit rx_pop, rx_push, tx_pop, tx_push, ovf_evt;
      rx_pop  = bus_sel && !bus_wr && !bus_addr && rxq.size() > 0;
      rx_push = host_rx_valid && rxq.size() < DEPTH;
      tx_pop  = host_tx_ready && txq.size() > 0;
      tx_push = bus_sel && bus_wr && !bus_addr && txq.size() < DEPTH;
      ovf_evt = bus_sel && bus_wr && !bus_addr && txq.size() == DEPTH;
      if (rx_pop) void'(rxq.pop_front());
      if (rx_push) rxq.push_back(host_rx_data);
      if (tx_pop) void'(txq.pop_front());
      if (tx_push) txq.push_back(bus_wdata[7:0]);
      if (bus_sel && bus_wr && bus_addr) begin
         m_rx_ie = bus_wdata[0];
         m_tx_ie = bus_wdata[1];
         if (bus_wdata[10]) m_act = 0;
         if (bus_wdata[11]) m_ovf = 0;
      end
      if (host_poll) m_act = 1;
      if (ovf_evt) m_ovf = 1;
   endtask

   task automatic tick();
      #1;
      compare();
      @(posedge clk);
      update();
      @(negedge clk);
      bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = '0;
      host_rx_valid = 0; host_poll = 0;
   endtask

   task automatic bus(input logic wr, input logic addr, input logic [31:0] wd);
      bus_sel = 1; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
   endtask

   task automatic read_ctrl();
      bus(0, 1, '0); tick();
   endtask

   initial begin
      #(5.0 * 200000);
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1;
      // reset state: R10 R11 R4
      tick();
      read_ctrl();
      // R9 enable both; tx empty makes irq high
      bus(1, 1, 32'h3); tick();
      tick();
      // R6 R4: processor writes 20 bytes with host stalled
      for (int i = 0; i < 20; i++) begin
         bus(1, 0, 32'hA00 + i); tick();
         read_ctrl();
      end
      // R1 R2: host fills receive FIFO past full
      for (int i = 0; i < 70; i++) begin
         host_rx_valid = 1; host_rx_data = 8'(i + 1); tick();
         read_ctrl();
      end
      // R1 R5: pops while host keeps offering at the full boundary
      for (int i = 0; i < 6; i++) begin
         bus(0, 0, '0); host_rx_valid = 1; host_rx_data = 8'hC0 + 8'(i); tick();
      end
      // R5 drain all plus empty reads
      for (int i = 0; i < DEPTH + 3; i++) begin
         bus(0, 0, '0); tick();
      end
      read_ctrl();
      // R3 early receive interrupt with end of input
      for (int i = 0; i < 3; i++) begin
         host_rx_valid = 1; host_rx_data = 8'h55 + 8'(i); tick();
      end
      read_ctrl();
      host_eoi = 1;
      read_ctrl();
      bus(0, 0, '0); tick();
      read_ctrl();
      host_eoi = 0;
      read_ctrl();
      // R6 host drains while processor writes
      host_tx_ready = 1;
      for (int i = 0; i < 30; i++) begin
         if (i % 3 != 0) bus(1, 0, 32'h100 + i);
         tick();
      end
      read_ctrl();
      // R7 overflow with host stalled
      host_tx_ready = 0;
      for (int i = 0; i < DEPTH + 6; i++) begin
         bus(1, 0, 32'h30 + i); tick();
      end
      read_ctrl();
      bus(1, 1, 32'h803); tick();
      read_ctrl();
      // R8 poll sets, write-1 clears, poll wins same cycle
      host_poll = 1; tick();
      read_ctrl();
      bus(1, 1, 32'h403); tick();
      read_ctrl();
      host_poll = 1; tick();
      bus(1, 1, 32'h403); host_poll = 1; tick();
      read_ctrl();
      bus(1, 1, 32'h003); tick();
      read_ctrl();
      // R9 masking combinations
      bus(1, 1, 32'h0); tick();
      read_ctrl();
      bus(1, 1, 32'h2); tick();
      host_tx_ready = 1;
      for (int i = 0; i < DEPTH + 4; i++) begin
         tick();
         if (i % 8 == 0) read_ctrl();
      end
      bus(1, 1, 32'h1); tick();
      read_ctrl();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule